// File: doc/BRIEF.md
# Doorbell Completion Reporting Unit

This block gathers the outcomes of outbound doorbell messages and hands them to software through a small 32-bit register window. Each outcome arrives on a one-cycle strobe carrying a 16-bit information value and a 2-bit result code. Two control bits decide which outcome classes are stored in a completion FIFO. Successful outcomes form one class. Error responses and time-outs form the other.

Software reads the completion data register to take the oldest stored entry. It then reads the completion status register to learn the result code of that entry. Three interrupt sources share one interrupt output, and each source has its own enable bit:

- a completion was stored;
- a completion was lost because the FIFO was full;
- an inbound doorbell was received, signalled by a separate strobe.

The overflow flag cannot be cleared until software has taken at least one entry since the overflow.

Top module: `dbell_cpl_report`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A completion with code 00 (done) is stored only while control bit 0 at offset 0x1C is set. Otherwise it is discarded.
- R3: A completion with code 01 (error response), 10 (time-out) or 11 is stored only while control bit 1 at offset 0x1C is set. Otherwise it is discarded.
- R4: A read of offset 0x14 returns the information value of the oldest stored entry in bits [15:0], with its low byte in bits [7:0]. The read removes that entry. Entries leave in arrival order.
- R5: Bits [1:0] of offset 0x18 hold the result code of the entry most recently removed through offset 0x14.
- R6: A read of offset 0x14 while the FIFO is empty returns zero and leaves offset 0x18 unchanged.
- R7: Interrupt status at offset 0x24 works as follows. Bit 1 sets when an entry is stored, and bit 0 sets on `rx_strobe`. Writing 1 to either bit clears it. A set event in the same cycle as a clear takes priority.
- R8: If a completion that passes the filter arrives while the FIFO is full, it is dropped, the stored entries stay unchanged, and status bit 2 sets.
- R9: Writing 1 to status bit 2 clears it only if at least one entry has been removed since the most recent overflow. Otherwise the write has no effect. The FIFO does not need to be emptied.
- R10: `irq` is the OR of the three status bits, each ANDed with the matching enable bit at offset 0x20 (bit 0 doorbell received, bit 1 completion stored, bit 2 overflow).
- R11: Every reserved register bit reads zero. Writes to reserved bits, to offsets 0x14 and 0x18, and to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpl_valid | input | 1 | One-cycle strobe: an outbound doorbell outcome is present |
| cpl_info | input | 16 | Information value of the completed doorbell |
| cpl_code | input | 2 | Result code: 00 done, 01 error response, 10 time-out |
| rx_strobe | input | 1 | One-cycle strobe: an inbound doorbell was received |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a data read pops at the clock edge |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid combinationally while reg_rd is high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the FIFO never holds more entries than its depth;
- a dropped completion leaves the FIFO full and its count unchanged;
- the stored and overflow flags rise after the matching events;
- a read of the empty FIFO leaves the status code unchanged;
- a clear of the overflow flag without a removal in between does nothing;
- `irq` stays low with all enables off.

Only the bench scenarios can show the data-dependent behaviour. These scenarios cover arrival order, the information values returned by reads, the filter outcome for each code class, and the full sequence of overflow, blocked clear, one removal and successful clear. They also cover the effect of each enable bit on `irq`.

// File: rtl/dbc_pkg.sv
// Package dbc_pkg
// Shared constants and types for the doorbell completion reporting unit.
// Assumes byte offsets in the register window and a fixed 16-bit info field.
package dbc_pkg;

    localparam int unsigned DBC_INFO_W = 16;
    localparam int unsigned DBC_CODE_W = 2;

    localparam logic [7:0] OFF_CPL_DATA = 8'h14;
    localparam logic [7:0] OFF_CPL_STAT = 8'h18;
    localparam logic [7:0] OFF_FILTER   = 8'h1C;
    localparam logic [7:0] OFF_IRQ_EN   = 8'h20;
    localparam logic [7:0] OFF_IRQ_STS  = 8'h24;

    typedef enum logic [DBC_CODE_W-1:0] {
        CODE_DONE    = 2'b00,
        CODE_ERROR   = 2'b01,
        CODE_TIMEOUT = 2'b10,
        CODE_OTHER   = 2'b11
    } cpl_code_e;

    typedef struct packed {
        logic [DBC_INFO_W-1:0] info;
        cpl_code_e             code;
    } cpl_entry_t;

    // Interrupt bit positions
    localparam int unsigned IRQ_RX    = 0;
    localparam int unsigned IRQ_AVAIL = 1;
    localparam int unsigned IRQ_OVF   = 2;
    localparam int unsigned IRQ_N     = 3;

endpackage

// File: rtl/dbc_filter.sv
// Module dbc_filter
// Decides whether an incoming completion is stored, based on its outcome class.
// Assumes a done code is class "success"; every other code is class "failure".
module dbc_filter
    import dbc_pkg::*;
(
    input  logic       cpl_valid,
    input  cpl_code_e  cpl_code,
    input  logic [1:0] keep_mask,   // [0] keep success, [1] keep failure
    output logic       accept
);

    logic is_success;

    // Classify the outcome and apply the matching keep bit.
    always_comb begin
        is_success = (cpl_code == CODE_DONE);
        accept     = cpl_valid && (is_success ? keep_mask[0] : keep_mask[1]);
    end

endmodule

// File: rtl/dbc_fifo.sv
// Module dbc_fifo
// Circular-buffer FIFO of completion entries, first-word view at the head.
// Assumes the caller never pushes when full nor pops when empty.
module dbc_fifo
    import dbc_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  cpl_entry_t               din,
    input  logic                     pop,
    output cpl_entry_t               head,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH-1);

    cpl_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    // Write the incoming entry into its slot.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Present the head entry and the level flags.
    always_comb begin
        head  = mem[rd_ptr];
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_W'(DEPTH));
        count = cnt_q;
    end

endmodule

// File: rtl/dbc_irq.sv
// Module dbc_irq
// Interrupt enable and status registers, overflow-clear guard, and irq output.
// Assumes set events take priority over write-1-to-clear in the same cycle.
module dbc_irq
    import dbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_rx,
    input  logic              set_avail,
    input  logic              set_ovf,
    input  logic              pop_evt,
    input  logic              en_wr,
    input  logic [IRQ_N-1:0]  en_wdata,
    input  logic              sts_wr,
    input  logic [IRQ_N-1:0]  sts_wdata,
    output logic [IRQ_N-1:0]  irq_en,
    output logic [IRQ_N-1:0]  irq_sts,
    output logic              drained,
    output logic              irq
);

    logic [IRQ_N-1:0] set_vec;
    logic [IRQ_N-1:0] clr_vec;

    // Gather set and clear requests; the overflow clear needs a drain first.
    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_RX]    = set_rx;
        set_vec[IRQ_AVAIL] = set_avail;
        set_vec[IRQ_OVF]   = set_ovf;
        clr_vec            = sts_wr ? sts_wdata : '0;
        clr_vec[IRQ_OVF]   = clr_vec[IRQ_OVF] & drained;
    end

    // Enable register, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
        end else if (en_wr) begin
            irq_en <= en_wdata;
        end
    end

    // Status bits: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_sts <= '0;
        end else begin
            irq_sts <= set_vec | (irq_sts & ~clr_vec);
        end
    end

    // Track whether an entry was removed since the last overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drained <= 1'b0;
        end else if (set_ovf) begin
            drained <= 1'b0;
        end else if (pop_evt) begin
            drained <= 1'b1;
        end
    end

    // Combine enabled sources into one request.
    always_comb begin
        irq = |(irq_sts & irq_en);
    end

endmodule

// File: rtl/dbell_cpl_report.sv
// Module dbell_cpl_report
// Top of the doorbell completion reporting unit: register decode, filter,
// completion FIFO, last-outcome register and interrupt logic.
// Assumes single-cycle strobes and combinational read data qualified by reg_rd.
module dbell_cpl_report
    import dbc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    input  logic [15:0]       cpl_info,
    input  logic [1:0]        cpl_code,
    input  logic              rx_strobe,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);

    logic             sel_data, sel_stat, sel_filt, sel_en, sel_sts;
    logic [1:0]       keep_mask;
    logic             accept;
    logic             push_ok, ovf_evt, pop_ok, rd_empty;
    cpl_entry_t       in_entry, head;
    logic             fifo_empty, fifo_full;
    logic [CNT_W-1:0] fifo_cnt;
    cpl_code_e        last_code;
    logic [IRQ_N-1:0] irq_en, irq_sts;
    logic             drained;

    // Address decode.
    always_comb begin
        sel_data = (reg_addr == ADDR_W'(OFF_CPL_DATA));
        sel_stat = (reg_addr == ADDR_W'(OFF_CPL_STAT));
        sel_filt = (reg_addr == ADDR_W'(OFF_FILTER));
        sel_en   = (reg_addr == ADDR_W'(OFF_IRQ_EN));
        sel_sts  = (reg_addr == ADDR_W'(OFF_IRQ_STS));
    end

    dbc_filter u_filter (
        .cpl_valid (cpl_valid),
        .cpl_code  (cpl_code_e'(cpl_code)),
        .keep_mask (keep_mask),
        .accept    (accept)
    );

    // Qualify push, drop and pop events.
    always_comb begin
        in_entry.info = cpl_info;
        in_entry.code = cpl_code_e'(cpl_code);
        push_ok  = accept && !fifo_full;
        ovf_evt  = accept && fifo_full;
        pop_ok   = reg_rd && sel_data && !fifo_empty;
        rd_empty = reg_rd && sel_data && fifo_empty;
    end

    dbc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .din   (in_entry),
        .pop   (pop_ok),
        .head  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    // Filter control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_mask <= '0;
        end else if (reg_wr && sel_filt) begin
            keep_mask <= reg_wdata[1:0];
        end
    end

    // Latch the outcome of each removed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_code <= CODE_DONE;
        end else if (pop_ok) begin
            last_code <= head.code;
        end
    end

    dbc_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_rx    (rx_strobe),
        .set_avail (push_ok),
        .set_ovf   (ovf_evt),
        .pop_evt   (pop_ok),
        .en_wr     (reg_wr && sel_en),
        .en_wdata  (reg_wdata[IRQ_N-1:0]),
        .sts_wr    (reg_wr && sel_sts),
        .sts_wdata (reg_wdata[IRQ_N-1:0]),
        .irq_en    (irq_en),
        .irq_sts   (irq_sts),
        .drained   (drained),
        .irq       (irq)
    );

    // Read data multiplexer; reserved bits are zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (sel_data && !fifo_empty) reg_rdata[DBC_INFO_W-1:0] = head.info;
            if (sel_stat)                reg_rdata[1:0]            = last_code;
            if (sel_filt)                reg_rdata[1:0]            = keep_mask;
            if (sel_en)                  reg_rdata[IRQ_N-1:0]      = irq_en;
            if (sel_sts)                 reg_rdata[IRQ_N-1:0]      = irq_sts;
        end
    end

endmodule

// File: rtl/dbc_checker.sv
// Module dbc_checker
// Temporal properties of the reporting unit, bound to the top module.
// Assumes it observes the top's internal event and state signals.
module dbc_checker #(
    parameter int unsigned FIFO_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           push_ok,
    input logic                           ovf_evt,
    input logic                           pop_ok,
    input logic                           rd_empty,
    input logic                           fifo_full,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
    input logic [2:0]                     irq_sts,
    input logic [2:0]                     irq_en,
    input logic                           drained,
    input logic [1:0]                     last_code,
    input logic                           reg_wr,
    input logic                           sel_sts,
    input logic [31:0]                    reg_wdata,
    input logic                           irq
);

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !pop_ok) |=> (fifo_full && $stable(fifo_cnt)));

    p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> irq_sts[2]);

    p_avail_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> irq_sts[1]);

    p_ovf_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sts[2] && !drained && reg_wr && sel_sts && reg_wdata[2]) |=> irq_sts[2]);

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |=> $stable(last_code));

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 3'b000) |-> !irq);

endmodule

bind dbell_cpl_report dbc_checker #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_ok   (push_ok),
    .ovf_evt   (ovf_evt),
    .pop_ok    (pop_ok),
    .rd_empty  (rd_empty),
    .fifo_full (fifo_full),
    .fifo_cnt  (fifo_cnt),
    .irq_sts   (irq_sts),
    .irq_en    (irq_en),
    .drained   (drained),
    .last_code (last_code),
    .reg_wr    (reg_wr),
    .sel_sts   (sel_sts),
    .reg_wdata (reg_wdata),
    .irq       (irq)
);

// File: tb/dbell_cpl_report_tb_top.sv
// Bench for dbell_cpl_report: directed corners plus seeded random traffic,
// compared against a behavioural model held in bench variables.
module dbell_cpl_report_tb_top;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpl_valid = 1'b0;
    logic [15:0] cpl_info = '0;
    logic [1:0]  cpl_code = '0;
    logic        rx_strobe = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic [15:0] m_info [DEPTH];
    logic [1:0]  m_code [DEPTH];
    int          m_cnt = 0;
    logic [1:0]  m_keep = 0;
    logic [2:0]  m_en = 0;
    logic [2:0]  m_sts = 0;
    logic        m_drained = 0;
    logic [1:0]  m_last = 0;

    always #10 clk = ~clk;

    dbell_cpl_report #(.FIFO_DEPTH(DEPTH), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_info(cpl_info),
        .cpl_code(cpl_code), .rx_strobe(rx_strobe), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_sts & m_en);
    endfunction

    function automatic void model_cpl(input logic [15:0] info, input logic [1:0] code);
        logic pass;
        pass = (code == 2'b00) ? m_keep[0] : m_keep[1];
        if (pass) begin
            if (m_cnt == DEPTH) begin
                m_sts[2]  = 1'b1;
                m_drained = 1'b0;
            end else begin
                m_info[m_cnt] = info;
                m_code[m_cnt] = code;
                m_cnt++;
                m_sts[1] = 1'b1;
            end
        end
    endfunction

    function automatic logic [31:0] model_pop();
        logic [31:0] v;
        v = '0;
        if (m_cnt > 0) begin
            v = {16'h0, m_info[0]};
            m_last = m_code[0];
            for (int i = 0; i < DEPTH-1; i++) begin
                m_info[i] = m_info[i+1];
                m_code[i] = m_code[i+1];
            end
            m_cnt--;
            m_drained = 1'b1;
        end
        return v;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h1C: m_keep = d[1:0];
            8'h20: m_en = d[2:0];
            8'h24: begin
                if (d[0]) m_sts[0] = 1'b0;
                if (d[1]) m_sts[1] = 1'b0;
                if (d[2] && m_drained) m_sts[2] = 1'b0;
            end
            default: ;
        endcase
    endfunction

    task automatic do_cpl(input logic [15:0] info, input logic [1:0] code);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_info = info; cpl_code = code;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
        model_cpl(info, code);
    endtask

    task automatic do_rx();
        @(negedge clk);
        rx_strobe = 1'b1;
        @(posedge clk); #1;
        rx_strobe = 1'b0;
        m_sts[0] = 1'b1;
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_rd(input logic [7:0] a, input string req, output logic [31:0] val);
        logic [31:0] exp;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        val = reg_rdata;
        case (a)
            8'h14: exp = model_pop();
            8'h18: exp = {30'h0, m_last};
            8'h1C: exp = {30'h0, m_keep};
            8'h20: exp = {29'h0, m_en};
            8'h24: exp = {29'h0, m_sts};
            default: exp = '0;
        endcase
        check(req, val, exp);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        do_rd(8'h18, req, v);
        do_rd(8'h1C, req, v);
        do_rd(8'h20, req, v);
        do_rd(8'h24, req, v);
        @(negedge clk);
        check({req, " R10 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        int unsigned r;
        r = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        check_all("R1 reset");
        do_rd(8'h14, "R1 R6 empty data read", v);

        // R2 R3 filter off discards everything
        do_cpl(16'h1111, 2'b00);
        do_cpl(16'h2222, 2'b01);
        do_cpl(16'h3333, 2'b10);
        do_rd(8'h14, "R2 R3 discarded when filter clear", v);
        check_all("R2 R3 no flags");

        // R2 only success kept
        do_wr(8'h1C, 32'h1);
        do_cpl(16'hA001, 2'b01);
        do_cpl(16'hA002, 2'b00);
        do_cpl(16'hA003, 2'b10);
        do_rd(8'h14, "R2 R4 success kept", v);
        do_rd(8'h18, "R5 code done", v);
        do_rd(8'h14, "R2 failures dropped", v);

        // R3 only failures kept; order and codes
        do_wr(8'h1C, 32'h2);
        do_cpl(16'hB001, 2'b00);
        do_cpl(16'hB002, 2'b10);
        do_cpl(16'hB003, 2'b01);
        do_cpl(16'hB004, 2'b11);
        do_rd(8'h14, "R3 R4 timeout entry", v);
        do_rd(8'h18, "R5 code timeout", v);
        do_rd(8'h14, "R3 R4 error entry", v);
        do_rd(8'h18, "R5 code error", v);
        do_rd(8'h14, "R3 R4 code 11 entry", v);
        do_rd(8'h14, "R6 empty read", v);
        do_rd(8'h18, "R6 status unchanged", v);

        // R7 flags and W1C, R10 enables
        do_rx();
        do_wr(8'h20, 32'h1);
        check_all("R7 R10 rx flag");
        do_wr(8'h24, 32'h3);
        check_all("R7 cleared");

        // R8 R9 overflow
        do_wr(8'h1C, 32'h3);
        do_wr(8'h20, 32'h4);
        for (int i = 0; i < DEPTH + 1; i++) do_cpl(16'hC000 + 16'(i), 2'(i % 3));
        check_all("R8 overflow flag");
        do_wr(8'h24, 32'h4);
        check_all("R9 clear blocked before drain");
        do_rd(8'h14, "R8 R4 head unchanged", v);
        do_wr(8'h24, 32'h4);
        check_all("R9 clear after one read");
        for (int i = 0; i < DEPTH; i++) do_rd(8'h14, "R8 R4 remaining entries", v);

        // R11 reserved bits and read-only offsets
        do_wr(8'h1C, 32'hFFFF_FFFC);
        do_wr(8'h20, 32'hFFFF_FFF8);
        do_wr(8'h14, 32'hFFFF_FFFF);
        do_wr(8'h18, 32'hFFFF_FFFF);
        do_wr(8'h40, 32'hFFFF_FFFF);
        check_all("R11 reserved ignored");

        // Random mix
        for (int n = 0; n < 800; n++) begin
            r = $urandom() % 10;
            case (r)
                0, 1, 2: do_cpl(16'($urandom()), 2'($urandom()));
                3:       do_rx();
                4, 5:    do_rd(8'h14, "R4 R5 random pop", v);
                6:       do_rd(8'h18, "R5 random status", v);
                7:       do_wr(8'h24, 32'($urandom() % 8));
                8:       do_wr(8'h20, 32'($urandom() % 8));
                default: do_wr(8'h1C, 32'($urandom() % 4));
            endcase
            if (n % 50 == 0) check_all("R7 R8 R9 R10 random");
        end
        check_all("R10 final");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule